// File: doc/BRIEF.md
# Byte-Addressed Program Counter with Return Stack and Computed Jump

This block holds the fetch address of a small processor core together with a hardware return stack and an 8-bit working register. The address counts bytes, and every instruction word takes two of them, so the address is always even. Each cycle the surrounding decode logic may raise one command strobe: advance to the next word, call a target, return while loading a literal into the working register, add the working register to the low address byte, or load the working register directly.

The computed jump and the return-with-literal command together give a table lookup. The caller puts an offset into the working register and calls a routine. That routine starts with the add-to-low-byte command, which lands on one of a run of return-with-literal entries. That entry returns to the caller with its constant in the working register. The offset counts bytes, and the lowest address bit is held at zero, so an odd offset can never reach an odd address.

Top module: `pcu_core`

## Requirements
- R1: On reset the program counter is 0x0000, the working register is 0x00, the overflow flag is 0 and the return stack is empty.
- R2: A step command advances the program counter by 2, modulo 2^PC_W.
- R3: A call pushes the program counter plus 2 onto the return stack and loads the target with bit 0 forced to 0.
- R4: A return-with-literal on a non-empty stack pops the top entry into the program counter and writes the literal into the working register.
- R5: An add command replaces the low 8 bits of the program counter with (low byte + working register) mod 256 and leaves the upper bits unchanged.
- R6: The sum an add produces has its bit 0 cleared, so an odd offset rounds the landing address down to an even byte.
- R7: Return addresses come back in last-in, first-out order for nesting up to the stack depth of 8.
- R8: A call onto a full stack sets the overflow flag, drops the new return address, keeps the 8 stored entries, and still jumps to the target.
- R9: A return-with-literal on an empty stack advances the program counter by 2, writes the literal, and leaves the overflow flag unchanged.
- R10: When several strobes are high at once, exactly one acts, in priority order call, return, add, load, step.
- R11: A load command writes the working register and leaves the program counter unchanged.
- R12: Once set, the overflow flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance to the next word |
| call_i | input | 1 | Call the address on call_tgt_i |
| call_tgt_i | input | PC_W | Call target byte address |
| ret_i | input | 1 | Return and load lit_i into the working register |
| lit_i | input | 8 | Literal for a return |
| add_i | input | 1 | Add the working register to the low address byte |
| load_i | input | 1 | Load wval_i into the working register |
| wval_i | input | 8 | Value for a load |
| pc_o | output | PC_W | Current byte address (bit 0 always 0) |
| wreg_o | output | 8 | Working register |
| ovf_o | output | 1 | Sticky return-stack overflow flag |

## Verification
The computed jump is swept over all 256 working-register values at four base addresses. One base sits at the start of a page, one near its top so the sum wraps, one has an odd target that must be forced even, and one sits at 0x00FE. Each sweep runs call, load, add and return in turn. It therefore separates correct 8-bit wrap from a carry into the upper byte, even from odd offsets, and a correct return address from a stale one. A nine-deep call chain followed by nine returns checks the stack order, the overflow at the full boundary and the empty-stack return. All strobes raised together, then fewer and fewer, check the priority. A step across 0xFFFE checks wrap-around of the full address.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_STEP,
        CMD_LOAD,
        CMD_ADD,
        CMD_RET,
        CMD_CALL
    } pcu_cmd_e;

    // Only one command acts per cycle; call wins, step loses.
    function automatic pcu_cmd_e pick_cmd(input logic call_s, input logic ret_s,
                                          input logic add_s, input logic load_s,
                                          input logic step_s);
        pcu_cmd_e c;
        if (call_s)      c = CMD_CALL;
        else if (ret_s)  c = CMD_RET;
        else if (add_s)  c = CMD_ADD;
        else if (load_s) c = CMD_LOAD;
        else if (step_s) c = CMD_STEP;
        else             c = CMD_NONE;
        return c;
    endfunction

endpackage

// File: rtl/pcu_stack.sv
module pcu_stack #(
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] wdata_i,
    output logic [ADDR_W-1:0] top_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              dropped_o
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][ADDR_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
    } stk_t;

    stk_t st_d, st_q;
    logic [IDX_W-1:0] top_idx;
    logic [IDX_W-1:0] wr_idx;

    assign empty_o   = (st_q.cnt == '0);
    assign full_o    = (st_q.cnt == CNT_W'(DEPTH));
    assign top_idx   = IDX_W'(st_q.cnt - CNT_W'(1));
    assign wr_idx    = IDX_W'(st_q.cnt);
    assign top_o     = empty_o ? '0 : st_q.mem[top_idx];
    assign dropped_o = push_i && full_o;

    always_comb begin
        st_d = st_q;
        if (push_i && !full_o) begin
            st_d.mem[wr_idx] = wdata_i;
            st_d.cnt         = st_q.cnt + CNT_W'(1);
        end else if (pop_i && !empty_o) begin
            st_d.cnt         = st_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R7: occupancy never exceeds the depth
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(DEPTH));

    // R8: a push onto a full stack changes nothing stored
    p_full_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o) |=> ($stable(st_q.cnt) && $stable(st_q.mem)));

    // R3: an accepted push becomes the new top
    p_push_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o) |=> (top_o == $past(wdata_i)));

    // R10: never a push and a pop in the same cycle
    p_one_op_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({push_i, pop_i}));

endmodule

// File: rtl/pcu_nextpc.sv
module pcu_nextpc
    import pcu_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int LOW_W = 8
) (
    input  pcu_cmd_e          cmd_i,
    input  logic [PC_W-1:0]   pc_i,
    input  logic [LOW_W-1:0]  wreg_i,
    input  logic [PC_W-1:0]   tgt_i,
    input  logic [LOW_W-1:0]  lit_i,
    input  logic [LOW_W-1:0]  wval_i,
    input  logic [PC_W-1:0]   stk_top_i,
    input  logic              stk_empty_i,
    output logic [PC_W-1:0]   pc_next_o,
    output logic [LOW_W-1:0]  wreg_next_o,
    output logic [PC_W-1:0]   ret_addr_o,
    output logic              push_o,
    output logic              pop_o
);
    localparam logic [PC_W-1:0]  EVEN_PC  = ~PC_W'(1);
    localparam logic [LOW_W-1:0] EVEN_LOW = ~LOW_W'(1);

    logic [LOW_W-1:0] low_sum;
    logic [PC_W-1:0]  pc_add;

    assign ret_addr_o = pc_i + PC_W'(2);
    assign low_sum    = (pc_i[LOW_W-1:0] + wreg_i) & EVEN_LOW;
    assign pc_add     = {pc_i[PC_W-1:LOW_W], low_sum};

    always_comb begin
        pc_next_o   = pc_i;
        wreg_next_o = wreg_i;
        push_o      = 1'b0;
        pop_o       = 1'b0;
        unique case (cmd_i)
            CMD_STEP: pc_next_o = ret_addr_o;
            CMD_LOAD: wreg_next_o = wval_i;
            CMD_ADD:  pc_next_o = pc_add;
            CMD_RET: begin
                wreg_next_o = lit_i;
                pop_o       = !stk_empty_i;
                pc_next_o   = stk_empty_i ? ret_addr_o : (stk_top_i & EVEN_PC);
            end
            CMD_CALL: begin
                push_o    = 1'b1;
                pc_next_o = tgt_i & EVEN_PC;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pcu_core.sv
module pcu_core
    import pcu_pkg::*;
#(
    parameter int PC_W      = 16,
    parameter int STK_DEPTH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            step_i,
    input  logic            call_i,
    input  logic [PC_W-1:0] call_tgt_i,
    input  logic            ret_i,
    input  logic [7:0]      lit_i,
    input  logic            add_i,
    input  logic            load_i,
    input  logic [7:0]      wval_i,
    output logic [PC_W-1:0] pc_o,
    output logic [7:0]      wreg_o,
    output logic            ovf_o
);
    localparam int LOW_W = 8;

    typedef struct packed {
        logic [PC_W-1:0]  pc;
        logic [LOW_W-1:0] wreg;
        logic             ovf;
    } core_t;

    core_t    st_d, st_q;
    pcu_cmd_e cmd;
    logic [PC_W-1:0]  pc_next, ret_addr, stk_top;
    logic [LOW_W-1:0] wreg_next;
    logic push, pop, stk_empty, stk_full, dropped;

    assign cmd = pick_cmd(call_i, ret_i, add_i, load_i, step_i);

    pcu_nextpc #(.PC_W(PC_W), .LOW_W(LOW_W)) u_nextpc (
        .cmd_i      (cmd),
        .pc_i       (st_q.pc),
        .wreg_i     (st_q.wreg),
        .tgt_i      (call_tgt_i),
        .lit_i      (lit_i),
        .wval_i     (wval_i),
        .stk_top_i  (stk_top),
        .stk_empty_i(stk_empty),
        .pc_next_o  (pc_next),
        .wreg_next_o(wreg_next),
        .ret_addr_o (ret_addr),
        .push_o     (push),
        .pop_o      (pop)
    );

    pcu_stack #(.ADDR_W(PC_W), .DEPTH(STK_DEPTH)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_i   (push),
        .pop_i    (pop),
        .wdata_i  (ret_addr),
        .top_o    (stk_top),
        .empty_o  (stk_empty),
        .full_o   (stk_full),
        .dropped_o(dropped)
    );

    always_comb begin
        st_d      = st_q;
        st_d.pc   = pc_next;
        st_d.wreg = wreg_next;
        st_d.ovf  = st_q.ovf | dropped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc_o   = st_q.pc;
    assign wreg_o = st_q.wreg;
    assign ovf_o  = st_q.ovf;

    // R2: step advances by one word
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_STEP) |=> (pc_o == $past(pc_o) + PC_W'(2)));

    // R5: add keeps the upper address bits
    p_add_upper_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADD) |=> (pc_o[PC_W-1:LOW_W] == $past(pc_o[PC_W-1:LOW_W])));

    // R6: add result lands on an even byte
    p_add_even_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADD) |=> (pc_o[0] == 1'b0));

    // R4: return writes the literal
    p_ret_lit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RET) |=> (wreg_o == $past(lit_i)));

    // R11: load leaves the address alone
    p_load_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOAD) |=> $stable(pc_o));

    // R12: overflow is sticky
    p_ovf_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> ovf_o);

    // R8: overflow rises only after a call on a full stack
    p_ovf_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_o) |-> $past(call_i && stk_full));

endmodule

// File: tb/pcu_core_bench.sv
module pcu_core_bench;
    localparam int PC_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic step_i = 0, call_i = 0, ret_i = 0, add_i = 0, load_i = 0;
    logic [PC_W-1:0] call_tgt_i = '0;
    logic [7:0] lit_i = '0, wval_i = '0;
    logic [PC_W-1:0] pc_o;
    logic [7:0] wreg_o;
    logic ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pcu_core #(.PC_W(PC_W), .STK_DEPTH(8)) u_pcu_core (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .call_i(call_i),
        .call_tgt_i(call_tgt_i), .ret_i(ret_i), .lit_i(lit_i), .add_i(add_i),
        .load_i(load_i), .wval_i(wval_i), .pc_o(pc_o), .wreg_o(wreg_o), .ovf_o(ovf_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Called at a falling edge; the result is visible at the next falling edge.
    task automatic op(input bit st, input bit ca, input bit rt, input bit ad, input bit ld,
                      input logic [PC_W-1:0] tgt, input logic [7:0] lit, input logic [7:0] wv);
        step_i = st; call_i = ca; ret_i = rt; add_i = ad; load_i = ld;
        call_tgt_i = tgt; lit_i = lit; wval_i = wv;
        @(negedge clk);
        step_i = 0; call_i = 0; ret_i = 0; add_i = 0; load_i = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [PC_W-1:0] exp_pc;
        logic [PC_W-1:0] ret_addr;
        logic [PC_W-1:0] rets [9];
        logic [PC_W-1:0] bases [4];
        logic [7:0] exp_w;
        bases[0] = 16'h1200; bases[1] = 16'h12F0; bases[2] = 16'hABCD; bases[3] = 16'h00FE;

        @(negedge clk);
        do_reset();
        chk("R1 pc", pc_o, 0);
        chk("R1 wreg", wreg_o, 0);
        chk("R1 ovf", ovf_o, 0);

        // R2 step sweep from reset
        exp_pc = '0;
        for (int i = 0; i < 20; i++) begin
            op(1, 0, 0, 0, 0, '0, '0, '0);
            exp_pc = exp_pc + 2;
            chk("R2 step", pc_o, exp_pc);
        end

        // R2 wrap across the top of the address space
        ret_addr = exp_pc + 2;
        op(0, 1, 0, 0, 0, 16'hFFFF, '0, '0);
        chk("R3 odd target", pc_o, 16'hFFFE);
        op(1, 0, 0, 0, 0, '0, '0, '0);
        chk("R2 wrap", pc_o, 16'h0000);
        op(0, 0, 1, 0, 0, '0, 8'h11, '0);
        chk("R4 return", pc_o, ret_addr);
        exp_pc = ret_addr;

        // R5/R6 computed-jump sweep
        for (int b = 0; b < 4; b++) begin
            for (int w = 0; w < 256; w++) begin
                logic [7:0] low;
                ret_addr = exp_pc + 2;
                op(0, 1, 0, 0, 0, bases[b], '0, '0);
                chk("R3 call", pc_o, bases[b] & 16'hFFFE);
                op(0, 0, 0, 0, 1, '0, '0, 8'(w));
                chk("R11 load w", wreg_o, w);
                chk("R11 load pc", pc_o, bases[b] & 16'hFFFE);
                op(0, 0, 0, 1, 0, '0, '0, '0);
                low = 8'((bases[b] & 16'h00FE) + w) & 8'hFE;
                chk("R5 R6 add", pc_o, {bases[b][15:8], low});
                op(0, 0, 1, 0, 0, '0, 8'(w) ^ 8'h5A, '0);
                chk("R4 ret pc", pc_o, ret_addr);
                chk("R4 ret w", wreg_o, 8'(w) ^ 8'h5A);
                exp_pc = ret_addr;
            end
        end

        // R7/R8 nesting to overflow
        for (int i = 0; i < 9; i++) begin
            rets[i] = exp_pc + 2;
            op(0, 1, 0, 0, 0, 16'h4001 + 16'(i * 256), '0, '0);
            exp_pc = 16'h4000 + 16'(i * 256);
            chk("R8 call pc", pc_o, exp_pc);
            chk("R8 ovf", ovf_o, (i == 8) ? 1 : 0);
        end
        for (int i = 7; i >= 0; i--) begin
            op(0, 0, 1, 0, 0, '0, 8'(i), '0);
            chk("R7 lifo", pc_o, rets[i]);
            exp_pc = rets[i];
        end
        // R9 empty return
        op(0, 0, 1, 0, 0, '0, 8'hC3, '0);
        exp_pc = exp_pc + 2;
        chk("R9 empty pc", pc_o, exp_pc);
        chk("R9 empty w", wreg_o, 8'hC3);
        chk("R12 ovf sticky", ovf_o, 1);

        // R10 priority
        ret_addr = exp_pc + 2;
        op(1, 1, 1, 1, 1, 16'h3456, 8'h77, 8'h99);
        chk("R10 call wins pc", pc_o, 16'h3456);
        chk("R10 call wins w", wreg_o, 8'hC3);
        op(1, 0, 1, 1, 1, '0, 8'h24, 8'h99);
        chk("R10 ret wins pc", pc_o, ret_addr);
        chk("R10 ret wins w", wreg_o, 8'h24);
        exp_pc = ret_addr;
        op(1, 0, 0, 1, 1, '0, '0, 8'h99);
        exp_pc = {exp_pc[15:8], 8'(exp_pc[7:0] + 8'h24) & 8'hFE};
        chk("R10 add wins pc", pc_o, exp_pc);
        chk("R10 add wins w", wreg_o, 8'h24);
        op(1, 0, 0, 0, 1, '0, '0, 8'h99);
        chk("R10 load wins pc", pc_o, exp_pc);
        chk("R10 load wins w", wreg_o, 8'h99);
        exp_w = 8'h99;
        chk("R12 ovf still", ovf_o, 1);

        do_reset();
        chk("R1 pc after", pc_o, 0);
        chk("R1 wreg after", wreg_o, 0);
        chk("R1 ovf cleared", ovf_o, 0);
        op(0, 0, 1, 0, 0, '0, exp_w, '0);
        chk("R1 R9 stack empty", pc_o, 2);

        finish_run();
    end
endmodule